// File: doc/BRIEF.md
# Byte-Serial Relative Branch Sequencer

This block is the instruction-fetch sequencer of a small 8-bit processor that has a 16-bit address bus. Every clock cycle it presents one address and takes in exactly one byte. After each opcode it always fetches the following byte, because the instruction length is not yet known at that point. Every instruction is two bytes long: an opcode, then an operand byte. For a relative branch, that operand byte is a signed displacement.

The block has only one 8-bit adder, so it cannot form a taken-branch target in a single step. It first adds the displacement to the low byte of the address that follows the displacement. It then fetches speculatively from the old high byte combined with the new low byte. While that fetch runs, the same adder corrects the high byte up or down when the low-byte add crossed a 256-byte page. If no page was crossed, the speculative byte is the next opcode. If a page was crossed, the speculative byte is thrown away and the fetch is repeated at the corrected address.

An external decoder tells the sequencer whether the opcode just fetched is a branch. A condition input tells it whether that branch is taken. At every opcode fetch the block reports the cycle count of the instruction that just ended.

Top module: `branch_seq`

## Requirements
- R1: While rst_ni is low, addr_o equals the parameter RESET_ADDR (default 16'h0000), op_valid_o is 1 and cyc_cnt_o is 0.
- R2: When start_i is high at a rising clock edge, the next cycle is an opcode fetch at start_addr_i with cyc_cnt_o equal to 0. This holds whatever state the sequencer was in.
- R3: The cycle after an opcode fetch at address A (op_valid_o high) always fetches A+1 with op_valid_o low. That byte is the operand, and for a branch it is the two's-complement displacement.
- R4: If is_branch_i is low at the end of the opcode cycle, or cond_i is low at the end of the operand cycle, the next opcode fetch is at A+2 in the third cycle, and cyc_cnt_o is 2 there.
- R5: For a taken branch, the third cycle presents A+2 with op_valid_o low. The byte fetched in that cycle is discarded.
- R6: Let B = A+2 and T = B + sign-extended displacement, modulo 2^16. If T lies in the same 256-byte page as B, the fourth cycle is an opcode fetch at T with cyc_cnt_o equal to 3.
- R7: If a positive displacement carries out of the low byte, the fourth cycle presents {B[15:8], T[7:0]} with op_valid_o low. The fifth cycle is an opcode fetch at T, whose high byte is B[15:8]+1, with cyc_cnt_o equal to 4.
- R8: If a negative displacement borrows out of the low byte, the fourth cycle presents {B[15:8], T[7:0]} with op_valid_o low. The fifth cycle is an opcode fetch at T, whose high byte is B[15:8]-1, with cyc_cnt_o equal to 4.
- R9: cond_i has no effect when the opcode was not a branch. op_valid_o is never high in two consecutive cycles unless start_i intervenes.
- R10: Target arithmetic wraps modulo 2^16: a taken branch crossing 16'hFFFF to 16'h0000 in either direction follows R7/R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Synchronous restart at start_addr_i |
| start_addr_i | input | 16 | Restart address |
| rdata_i | input | 8 | Byte read at addr_o, sampled at the end of the cycle |
| is_branch_i | input | 1 | Opcode-class decode of the current opcode byte, sampled at the end of the opcode cycle |
| cond_i | input | 1 | Branch condition, sampled at the end of the operand cycle |
| addr_o | output | 16 | Bus address for the current cycle |
| op_valid_o | output | 1 | The current cycle fetches a new opcode |
| cyc_cnt_o | output | 3 | Cycle count of the previous instruction, valid while op_valid_o is high |

## Verification
A wrong internal state shows up on addr_o within one cycle. A stale displacement or a wrong adder operand gives a wrong low byte in the cycle right after the dummy fetch. A wrong crossing direction or a wrong carry decision gives a wrong high byte, or a missing or extra correction cycle, in the next one or two cycles. A wrong cycle counter shows on cyc_cnt_o at the very next opcode fetch. Random branches from random start pages, together with directed forward, backward and wrap-around page crossings, expose each of these paths at the ports.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [1:0] {
    ST_OP  = 2'd0,  // opcode fetch
    ST_OPR = 2'd1,  // operand / displacement fetch
    ST_ADD = 2'd2,  // dummy fetch, low-byte add
    ST_FIX = 2'd3   // speculative fetch discarded, high-byte fix
  } seq_state_e;
endpackage

// File: rtl/byte_adder.sv
module byte_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] full;
  assign full   = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
  assign sum_o  = full[W-1:0];
  assign cout_o = full[W];
endmodule

// File: rtl/addr_incr.sv
module addr_incr #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  output logic [W-1:0] y_o
);
  assign y_o = a_i + W'(1);
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             is_branch_i,
  input  logic             cond_i,
  input  logic             fix_i,
  output seq_state_e       state_o,
  output logic [CNT_W-1:0] cyc_cnt_o
);
  seq_state_e       state_q, state_n;
  logic             br_q, br_n;
  logic [CNT_W-1:0] cnt_q, cyc_q;

  always_comb begin
    state_n = state_q;
    br_n    = br_q;
    case (state_q)
      ST_OP: begin
        state_n = ST_OPR;
        br_n    = is_branch_i;
      end
      ST_OPR:  state_n = (br_q && cond_i) ? ST_ADD : ST_OP;
      ST_ADD:  state_n = fix_i ? ST_FIX : ST_OP;
      ST_FIX:  state_n = ST_OP;
      default: state_n = ST_OP;
    endcase
    if (start_i) state_n = ST_OP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OP;
      br_q    <= 1'b0;
      cnt_q   <= '0;
      cyc_q   <= '0;
    end else begin
      state_q <= state_n;
      br_q    <= br_n;
      if (start_i) begin
        cnt_q <= '0;
        cyc_q <= '0;
      end else if (state_n == ST_OP) begin
        cnt_q <= '0;
        cyc_q <= cnt_q + CNT_W'(1);
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign state_o   = state_q;
  assign cyc_cnt_o = cyc_q;
endmodule

// File: rtl/branch_seq.sv
module branch_seq
  import seq_pkg::*;
#(
  parameter int          DATA_W     = 8,
  parameter int          CNT_W      = 3,
  parameter logic [15:0] RESET_ADDR = 16'h0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [15:0]       start_addr_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              is_branch_i,
  input  logic              cond_i,
  output logic [15:0]       addr_o,
  output logic              op_valid_o,
  output logic [CNT_W-1:0]  cyc_cnt_o
);
  localparam int ADDR_W = 2 * DATA_W;

  seq_state_e        state;
  logic [ADDR_W-1:0] addr_q, addr_n, addr_inc;
  logic [DATA_W-1:0] off_q, add_a, add_b, add_sum;
  logic              dir_q, add_cin, add_cout, fix;
  logic [DATA_W-1:0] hi_q, lo_q;

  assign hi_q = addr_q[ADDR_W-1:DATA_W];
  assign lo_q = addr_q[DATA_W-1:0];

  addr_incr #(.W(ADDR_W)) u_inc (.a_i(addr_q), .y_o(addr_inc));

  // single shared byte adder: low byte in ST_ADD, high byte in ST_FIX
  always_comb begin
    add_a   = '0;
    add_b   = '0;
    add_cin = 1'b0;
    case (state)
      ST_ADD: begin
        add_a = lo_q;
        add_b = off_q;
      end
      ST_FIX: begin
        add_a   = hi_q;
        add_b   = dir_q ? {DATA_W{1'b1}} : '0;
        add_cin = ~dir_q;
      end
      default: ;
    endcase
  end

  byte_adder #(.W(DATA_W)) u_add (
    .a_i(add_a), .b_i(add_b), .cin_i(add_cin),
    .sum_o(add_sum), .cout_o(add_cout)
  );

  // carry with positive offset or no carry with negative offset: page crossed
  assign fix = (state == ST_ADD) && (add_cout ^ off_q[DATA_W-1]);

  seq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .is_branch_i(is_branch_i), .cond_i(cond_i), .fix_i(fix),
    .state_o(state), .cyc_cnt_o(cyc_cnt_o)
  );

  always_comb begin
    case (state)
      ST_ADD:  addr_n = {hi_q, add_sum};
      ST_FIX:  addr_n = {add_sum, lo_q};
      default: addr_n = addr_inc;
    endcase
    if (start_i) addr_n = start_addr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= RESET_ADDR;
      off_q  <= '0;
      dir_q  <= 1'b0;
    end else begin
      addr_q <= addr_n;
      if (state == ST_OPR) off_q <= rdata_i;
      if (state == ST_ADD) dir_q <= off_q[DATA_W-1];
    end
  end

  assign addr_o     = addr_q;
  assign op_valid_o = (state == ST_OP);
endmodule

// File: rtl/branch_seq_chk.sv
module branch_seq_chk #(
  parameter int CNT_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [15:0]      addr_o,
  input logic             op_valid_o,
  input logic [CNT_W-1:0] cyc_cnt_o
);
  // R3
  operand_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && !start_i) |=> (!op_valid_o && addr_o == $past(addr_o) + 16'd1));

  // R4
  short_next_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && cyc_cnt_o == CNT_W'(2)) |-> (addr_o == $past(addr_o) + 16'd1));

  // R6
  same_page_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && cyc_cnt_o == CNT_W'(3)) |-> (addr_o[15:8] == $past(addr_o[15:8])));

  // R7
  cross_fix_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && cyc_cnt_o == CNT_W'(4)) |->
      (addr_o[7:0] == $past(addr_o[7:0]) &&
       (addr_o[15:8] == $past(addr_o[15:8]) + 8'd1 ||
        addr_o[15:8] == $past(addr_o[15:8]) - 8'd1)));

  // R9
  cnt_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o |-> (cyc_cnt_o == CNT_W'(0) || cyc_cnt_o == CNT_W'(2) ||
                    cyc_cnt_o == CNT_W'(3) || cyc_cnt_o == CNT_W'(4)));

  // R2
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (op_valid_o && cyc_cnt_o == CNT_W'(0)));
endmodule

bind branch_seq branch_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
  .addr_o(addr_o), .op_valid_o(op_valid_o), .cyc_cnt_o(cyc_cnt_o)
);

// File: tb/branch_seq_tb.sv
module branch_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] RST_ADDR = 16'h0000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] start_addr_i = '0;
  logic [7:0]  rdata_i = '0;
  logic        is_branch_i = 1'b0;
  logic        cond_i = 1'b0;
  logic [15:0] addr_o;
  logic        op_valid_o;
  logic [2:0]  cyc_cnt_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] exp_pc;
  logic [2:0]  exp_cyc;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_seq #(.RESET_ADDR(RST_ADDR)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .start_addr_i(start_addr_i),
    .rdata_i(rdata_i), .is_branch_i(is_branch_i), .cond_i(cond_i),
    .addr_o(addr_o), .op_valid_o(op_valid_o), .cyc_cnt_o(cyc_cnt_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] target(input logic [15:0] base, input logic [7:0] off);
    return base + {{8{off[7]}}, off};
  endfunction

  task automatic chk_fetch(input logic [15:0] a, input bit opv, input string req);
    chk(addr_o == a, req, {16'h0, addr_o}, {16'h0, a});
    chk(op_valid_o == opv, req, {31'h0, op_valid_o}, {31'h0, opv});
  endtask

  // entry and exit at a negedge with an opcode fetch presented
  task automatic do_instr(input bit br, input bit cond, input logic [7:0] off, input string req);
    logic [15:0] base, tgt;
    chk_fetch(exp_pc, 1'b1, req);
    chk(cyc_cnt_o == exp_cyc, req, {29'h0, cyc_cnt_o}, {29'h0, exp_cyc});
    is_branch_i = br;
    cond_i      = 1'($urandom);  // R9: no effect in opcode cycle
    rdata_i     = 8'($urandom);
    @(negedge clk);
    chk_fetch(exp_pc + 16'd1, 1'b0, "R3");
    is_branch_i = 1'($urandom);
    rdata_i     = off;
    cond_i      = br ? cond : 1'($urandom);  // R9
    @(negedge clk);
    base = exp_pc + 16'd2;
    if (!(br && cond)) begin
      exp_pc  = base;
      exp_cyc = 3'd2;  // R4
      return;
    end
    tgt = target(base, off);
    chk_fetch(base, 1'b0, "R5");
    rdata_i = 8'($urandom);
    @(negedge clk);
    if (tgt[15:8] != base[15:8]) begin
      chk_fetch({base[15:8], tgt[7:0]}, 1'b0, off[7] ? "R8" : "R7");
      @(negedge clk);
      exp_cyc = 3'd4;
    end else begin
      exp_cyc = 3'd3;  // R6
    end
    exp_pc = tgt;
  endtask

  task automatic do_start(input logic [15:0] a);
    start_i = 1'b1;
    start_addr_i = a;
    @(negedge clk);
    start_i = 1'b0;
    exp_pc  = a;
    exp_cyc = 3'd0;
    chk_fetch(a, 1'b1, "R2");
    chk(cyc_cnt_o == 3'd0, "R2", {29'h0, cyc_cnt_o}, 32'h0);
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 1, 0);
      finish_up();
    end
  end

  initial begin
    void'($urandom(32'd2024));
    #(CLK_PERIOD * 2);
    // R1: reset state
    chk_fetch(RST_ADDR, 1'b1, "R1");
    chk(cyc_cnt_o == 3'd0, "R1", {29'h0, cyc_cnt_o}, 32'h0);
    @(negedge clk);
    rst_ni = 1'b1;
    exp_pc = RST_ADDR;
    exp_cyc = 3'd0;

    do_instr(1'b0, 1'b1, 8'h55, "R1");        // non-branch, cond high
    do_instr(1'b1, 1'b0, 8'h80, "R4");        // branch not taken
    do_start(16'h3400);
    do_instr(1'b1, 1'b1, 8'h10, "R2");        // same page forward
    do_instr(1'b1, 1'b1, 8'h00, "R6");        // zero offset
    do_instr(1'b1, 1'b1, 8'hFE, "R6");        // back onto own opcode
    do_instr(1'b0, 1'b0, 8'h00, "R6");
    do_start(16'h12F0);
    do_instr(1'b1, 1'b1, 8'h7F, "R2");        // R7 forward crossing
    do_instr(1'b0, 1'b0, 8'h00, "R7");
    do_start(16'h1200);
    do_instr(1'b1, 1'b1, 8'h80, "R2");        // R8 backward crossing
    do_instr(1'b0, 1'b0, 8'h00, "R8");
    do_start(16'hFFF0);
    do_instr(1'b1, 1'b1, 8'h20, "R2");        // R10 wrap forward
    do_instr(1'b0, 1'b0, 8'h00, "R10");
    do_start(16'h0002);
    do_instr(1'b1, 1'b1, 8'hF0, "R2");        // R10 wrap backward
    do_instr(1'b0, 1'b0, 8'h00, "R10");

    // start in mid-branch (R2)
    chk_fetch(exp_pc, 1'b1, "R2");
    is_branch_i = 1'b1;
    @(negedge clk);
    rdata_i = 8'h40;
    cond_i  = 1'b1;
    @(negedge clk);
    do_start(16'h5678);

    for (int i = 0; i < 400; i++) begin
      if (($urandom % 40) == 0) do_start(16'($urandom));
      do_instr(1'($urandom), 1'($urandom), 8'($urandom), "R6");
    end
    do_instr(1'b0, 1'b0, 8'h00, "R4");

    done = 1;
    finish_up();
  end
endmodule